// File: doc/BRIEF.md
# Exception Entry Controller

This block computes the processor state updates for the cycle in which a 32-bit core with branch delay slots takes an exception. Each cycle it looks at four request lines: soft reset, non-maskable interrupt, debug and general exception. It also sees the faulting PC, a flag that marks the faulting instruction as sitting in a delay slot, and the current Status and Cause values. It picks one request by fixed priority. One clock later it presents the new PC, the return address for the chosen entry path, the new Status and Cause values and the mode-flag set pulses. Each of these comes with its own write enable, and the surrounding core commits them.

There are three entry paths, and each has its own vector and its own return-address register. A debug entry writes the debug return register. Soft reset and NMI write the error return register. A general exception writes the ordinary exception return register. For a general exception the base address depends on the boot-vector bit in Status, and a per-type offset is added to it. An unsupported general exception type writes no state and raises an error flag instead.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released with no request, every write enable, set pulse and `err_o` is 0.
- R2: All outputs are registered. A request sampled at one rising edge shows its results after that edge and holds them for exactly one cycle.
- R3: Request bits are `req_i[3]` soft reset, `req_i[2]` NMI, `req_i[1]` debug and `req_i[0]` general. When several are set, only the highest-numbered one is taken.
- R4: A debug entry writes `depc_o`, sets `pc_o` to 0xBFC00480 and pulses `dm_set_o`. It writes neither Status nor Cause.
- R5: On every taken entry the return address is `pc_i - 4` when `in_ds_i` is 1 and `pc_i` when it is 0, and `bd_clr_o` pulses.
- R6: A soft reset writes `errorepc_o` and loads Status with only bit 20 (soft reset), bit 22 (boot vector) and bit 2 (error level) set. It also pulses `watch_clr_o` and `erl_set_o` and sets `pc_o` to 0xBFC00000.
- R7: An NMI acts as in R6 but loads Status bit 19 instead of bit 20, and it does not pulse `watch_clr_o`.
- R8: A general exception writes `epc_o`. It writes Cause with bits 6:2 set to `gen_code_i` and bit 31 set to `in_ds_i`, and every other bit is taken from `cause_i`.
- R9: The general vector is 0xBFC00200 when `status_i[22]` is 1 and 0x80000000 when it is 0. To this base it adds 0x000 when `gen_refill_i` is 1 and 0x180 otherwise.
- R10: A general exception writes Status as `status_i` with bit 1 (exception level) set, and it pulses `exl_set_o`.
- R11: A general request wins only when no other request is set. In that case, if the code is outside {0..13, 23, 24}, or if `gen_refill_i` is 1 with a code other than 2 or 3, `err_o` pulses and no write enable, set pulse or `bd_clr_o` is raised.
- R12: A machine check (code 24) is accepted, and its code appears in Cause bits 6:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 4 | Request lines: soft reset, NMI, debug, general |
| gen_code_i | input | 5 | Exception code of the general request |
| gen_refill_i | input | 1 | General request is a translation refill |
| pc_i | input | 32 | PC of the faulting instruction |
| in_ds_i | input | 1 | Faulting instruction sits in a delay slot |
| status_i | input | 32 | Current Status value |
| cause_i | input | 32 | Current Cause value |
| pc_o | output | 32 | New PC |
| pc_we_o | output | 1 | New PC valid |
| epc_o | output | 32 | General exception return address |
| epc_we_o | output | 1 | Write enable for epc_o |
| errorepc_o | output | 32 | Error-class return address |
| errorepc_we_o | output | 1 | Write enable for errorepc_o |
| depc_o | output | 32 | Debug return address |
| depc_we_o | output | 1 | Write enable for depc_o |
| status_o | output | 32 | New Status |
| status_we_o | output | 1 | Write enable for status_o |
| cause_o | output | 32 | New Cause |
| cause_we_o | output | 1 | Write enable for cause_o |
| watch_clr_o | output | 1 | Clear the watch-low register |
| dm_set_o | output | 1 | Set debug mode |
| erl_set_o | output | 1 | Set error-level mode |
| exl_set_o | output | 1 | Set exception-level mode |
| bd_clr_o | output | 1 | Clear the delay-slot flag |
| err_o | output | 1 | Unsupported general exception type |

## Verification
The assertions assume that reset is held for at least one clock edge and that `req_i` is 0 while reset is asserted. They also assume that every input is a known value whenever reset is released. The bench holds all inputs at 0 during reset and drives them only on falling edges. It then runs directed cases followed by random requests, codes, PCs and Status/Cause values. All of these are fully defined, so every property sees clean values.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int XLEN     = 32;
    localparam int ST_EXL   = 1;
    localparam int ST_ERL   = 2;
    localparam int ST_NMI   = 19;
    localparam int ST_SR    = 20;
    localparam int ST_BEV   = 22;
    localparam int CA_BD    = 31;
    localparam int CODE_LO  = 2;
    localparam int CODE_W   = 5;
    localparam int NREQ     = 4;
    localparam int REQ_SRST = 3;
    localparam int REQ_NMI  = 2;
    localparam int REQ_DBG  = 1;
    localparam int REQ_GEN  = 0;

    typedef enum logic [2:0] {
        PATH_NONE,
        PATH_SRST,
        PATH_NMI,
        PATH_DBG,
        PATH_GEN
    } path_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic            pc_we;
        logic [XLEN-1:0] epc;
        logic            epc_we;
        logic [XLEN-1:0] errorepc;
        logic            errorepc_we;
        logic [XLEN-1:0] depc;
        logic            depc_we;
        logic [XLEN-1:0] status;
        logic            status_we;
        logic [XLEN-1:0] cause;
        logic            cause_we;
        logic            watch_clr;
        logic            dm_set;
        logic            erl_set;
        logic            exl_set;
        logic            bd_clr;
        logic            err;
    } entry_t;
endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
    import exc_entry_pkg::*;
(
    input  logic [NREQ-1:0] req_i,
    output path_e           path_o
);
    always_comb begin
        if (req_i[REQ_SRST])      path_o = PATH_SRST;
        else if (req_i[REQ_NMI])  path_o = PATH_NMI;
        else if (req_i[REQ_DBG])  path_o = PATH_DBG;
        else if (req_i[REQ_GEN])  path_o = PATH_GEN;
        else                      path_o = PATH_NONE;
    end
endmodule

// File: rtl/exc_ret_addr.sv
module exc_ret_addr #(
    parameter int W    = 32,
    parameter int STEP = 4
) (
    input  logic [W-1:0] pc_i,
    input  logic         in_ds_i,
    output logic [W-1:0] ret_o
);
    localparam logic [W-1:0] STEP_V = W'(STEP);

    always_comb ret_o = in_ds_i ? (pc_i - STEP_V) : pc_i;
endmodule

// File: rtl/exc_gen_decode.sv
module exc_gen_decode #(
    parameter int W          = 32,
    parameter int CW         = 5,
    parameter int REFILL_OFS = 'h000,
    parameter int OTHER_OFS  = 'h180
) (
    input  logic [CW-1:0] code_i,
    input  logic          refill_i,
    output logic          ok_o,
    output logic [W-1:0]  ofs_o
);
    localparam logic [CW-1:0] LAST_PLAIN = CW'(13);
    localparam logic [CW-1:0] CODE_WATCH = CW'(23);
    localparam logic [CW-1:0] CODE_MCHK  = CW'(24);
    localparam logic [CW-1:0] CODE_TLBL  = CW'(2);
    localparam logic [CW-1:0] CODE_TLBS  = CW'(3);

    logic known;
    logic refill_fit;

    always_comb begin
        known      = (code_i <= LAST_PLAIN) || (code_i == CODE_WATCH) || (code_i == CODE_MCHK);
        refill_fit = (code_i == CODE_TLBL) || (code_i == CODE_TLBS);
        ok_o       = known && (!refill_i || refill_fit);
        ofs_o      = refill_i ? W'(REFILL_OFS) : W'(OTHER_OFS);
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter logic [31:0] DBG_VEC   = 32'hBFC0_0480,
    parameter logic [31:0] ERR_VEC   = 32'hBFC0_0000,
    parameter logic [31:0] BOOT_BASE = 32'hBFC0_0200,
    parameter logic [31:0] RUN_BASE  = 32'h8000_0000,
    parameter int          INSN_B    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [3:0]      req_i,
    input  logic [4:0]      gen_code_i,
    input  logic            gen_refill_i,
    input  logic [31:0]     pc_i,
    input  logic            in_ds_i,
    input  logic [31:0]     status_i,
    input  logic [31:0]     cause_i,
    output logic [31:0]     pc_o,
    output logic            pc_we_o,
    output logic [31:0]     epc_o,
    output logic            epc_we_o,
    output logic [31:0]     errorepc_o,
    output logic            errorepc_we_o,
    output logic [31:0]     depc_o,
    output logic            depc_we_o,
    output logic [31:0]     status_o,
    output logic            status_we_o,
    output logic [31:0]     cause_o,
    output logic            cause_we_o,
    output logic            watch_clr_o,
    output logic            dm_set_o,
    output logic            erl_set_o,
    output logic            exl_set_o,
    output logic            bd_clr_o,
    output logic            err_o
);
    localparam logic [XLEN-1:0] M_EXL = XLEN'(1) << ST_EXL;
    localparam logic [XLEN-1:0] M_ERL = XLEN'(1) << ST_ERL;
    localparam logic [XLEN-1:0] M_NMI = XLEN'(1) << ST_NMI;
    localparam logic [XLEN-1:0] M_SR  = XLEN'(1) << ST_SR;
    localparam logic [XLEN-1:0] M_BEV = XLEN'(1) << ST_BEV;

    path_e           path;
    logic [XLEN-1:0] ret_addr;
    logic            gen_ok;
    logic [XLEN-1:0] gen_ofs;
    entry_t          ent_d, ent_q;

    exc_prio_sel u_sel (
        .req_i  (req_i),
        .path_o (path)
    );

    exc_ret_addr #(.W(XLEN), .STEP(INSN_B)) u_ret (
        .pc_i    (pc_i),
        .in_ds_i (in_ds_i),
        .ret_o   (ret_addr)
    );

    exc_gen_decode #(.W(XLEN), .CW(CODE_W)) u_dec (
        .code_i   (gen_code_i),
        .refill_i (gen_refill_i),
        .ok_o     (gen_ok),
        .ofs_o    (gen_ofs)
    );

    always_comb begin
        ent_d = '0;
        unique case (path)
            PATH_SRST, PATH_NMI: begin
                ent_d.errorepc    = ret_addr;
                ent_d.errorepc_we = 1'b1;
                ent_d.status      = ((path == PATH_SRST) ? M_SR : M_NMI) | M_ERL | M_BEV;
                ent_d.status_we   = 1'b1;
                ent_d.watch_clr   = (path == PATH_SRST);
                ent_d.erl_set     = 1'b1;
                ent_d.pc          = ERR_VEC;
                ent_d.pc_we       = 1'b1;
                ent_d.bd_clr      = 1'b1;
            end
            PATH_DBG: begin
                ent_d.depc    = ret_addr;
                ent_d.depc_we = 1'b1;
                ent_d.dm_set  = 1'b1;
                ent_d.pc      = DBG_VEC;
                ent_d.pc_we   = 1'b1;
                ent_d.bd_clr  = 1'b1;
            end
            PATH_GEN: begin
                if (gen_ok) begin
                    ent_d.epc                       = ret_addr;
                    ent_d.epc_we                    = 1'b1;
                    ent_d.cause                     = cause_i;
                    ent_d.cause[CODE_LO +: CODE_W]  = gen_code_i;
                    ent_d.cause[CA_BD]              = in_ds_i;
                    ent_d.cause_we                  = 1'b1;
                    ent_d.status                    = status_i | M_EXL;
                    ent_d.status_we                 = 1'b1;
                    ent_d.exl_set                   = 1'b1;
                    ent_d.pc    = (status_i[ST_BEV] ? BOOT_BASE : RUN_BASE) + gen_ofs;
                    ent_d.pc_we = 1'b1;
                    ent_d.bd_clr = 1'b1;
                end else begin
                    ent_d.err = 1'b1;
                end
            end
            default: ent_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign pc_o          = ent_q.pc;
    assign pc_we_o       = ent_q.pc_we;
    assign epc_o         = ent_q.epc;
    assign epc_we_o      = ent_q.epc_we;
    assign errorepc_o    = ent_q.errorepc;
    assign errorepc_we_o = ent_q.errorepc_we;
    assign depc_o        = ent_q.depc;
    assign depc_we_o     = ent_q.depc_we;
    assign status_o      = ent_q.status;
    assign status_we_o   = ent_q.status_we;
    assign cause_o       = ent_q.cause;
    assign cause_we_o    = ent_q.cause_we;
    assign watch_clr_o   = ent_q.watch_clr;
    assign dm_set_o      = ent_q.dm_set;
    assign erl_set_o     = ent_q.erl_set;
    assign exl_set_o     = ent_q.exl_set;
    assign bd_clr_o      = ent_q.bd_clr;
    assign err_o         = ent_q.err;

    // R3: at most one entry path (or the error) per cycle
    a_r3_one_path: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({epc_we_o, errorepc_we_o, depc_we_o, err_o}));

    // R4: debug entry jumps to the debug vector and leaves Status/Cause alone
    a_r4_dbg_vector: assert property (@(posedge clk) disable iff (!rst_n)
        depc_we_o |-> (pc_we_o && pc_o == DBG_VEC && dm_set_o && !status_we_o && !cause_we_o));

    // R6: error-class entry carries ERL and BEV and the error vector
    a_r6_err_status: assert property (@(posedge clk) disable iff (!rst_n)
        errorepc_we_o |-> (status_o[ST_ERL] && status_o[ST_BEV] && pc_o == ERR_VEC && erl_set_o));

    // R10: a general entry always raises the exception level
    a_r10_gen_exl: assert property (@(posedge clk) disable iff (!rst_n)
        epc_we_o |-> (status_o[ST_EXL] && exl_set_o && cause_we_o));

    // R11: an unsupported type commits nothing
    a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!pc_we_o && !status_we_o && !cause_we_o && !bd_clr_o && !watch_clr_o));

    // R2: a soft reset request shows up one cycle later
    a_r2_srst_latency: assert property (@(posedge clk) disable iff (!rst_n)
        req_i[REQ_SRST] |=> (errorepc_we_o && status_o[ST_SR]));

    // R5: debug return address corrected for the delay slot
    a_r5_dbg_ret: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == 4'b0010) |=> (depc_o == ($past(pc_i) - ($past(in_ds_i) ? 32'(INSN_B) : 32'd0))));
endmodule

// File: tb/exc_entry_ctrl_tb_top.sv
module exc_entry_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  req;
    logic [4:0]  code;
    logic        refill;
    logic [31:0] pc, status, cause;
    logic        in_ds;

    logic [31:0] pc_o, epc_o, errorepc_o, depc_o, status_o, cause_o;
    logic pc_we_o, epc_we_o, errorepc_we_o, depc_we_o, status_we_o, cause_we_o;
    logic watch_clr_o, dm_set_o, erl_set_o, exl_set_o, bd_clr_o, err_o;

    int checks = 0;
    int errors = 0;

    // expected values for the next compare
    logic [11:0] e_we;
    logic [31:0] e_pc, e_ret, e_status, e_cause;
    string       tag;

    always #5 clk = ~clk;

    exc_entry_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .gen_code_i(code), .gen_refill_i(refill),
        .pc_i(pc), .in_ds_i(in_ds), .status_i(status), .cause_i(cause),
        .pc_o(pc_o), .pc_we_o(pc_we_o), .epc_o(epc_o), .epc_we_o(epc_we_o),
        .errorepc_o(errorepc_o), .errorepc_we_o(errorepc_we_o),
        .depc_o(depc_o), .depc_we_o(depc_we_o), .status_o(status_o), .status_we_o(status_we_o),
        .cause_o(cause_o), .cause_we_o(cause_we_o), .watch_clr_o(watch_clr_o),
        .dm_set_o(dm_set_o), .erl_set_o(erl_set_o), .exl_set_o(exl_set_o),
        .bd_clr_o(bd_clr_o), .err_o(err_o)
    );

    task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    // we-vector bit order: pc epc errorepc depc status cause watch dm erl exl bd err
    function automatic logic [11:0] we_vec();
        return {pc_we_o, epc_we_o, errorepc_we_o, depc_we_o, status_we_o, cause_we_o,
                watch_clr_o, dm_set_o, erl_set_o, exl_set_o, bd_clr_o, err_o};
    endfunction

    task automatic model();
        int  n = 0;
        logic ok;
        for (int i = 0; i < 4; i++) n += int'(req[i]);
        e_we = '0; e_pc = '0; e_status = '0; e_cause = '0;
        e_ret = in_ds ? pc - 32'd4 : pc;
        tag = "R2 idle";
        if (req[3] || req[2]) begin
            tag = req[3] ? "R6 soft reset" : "R7 nmi";
            e_status = (req[3] ? 32'h0010_0000 : 32'h0008_0000) | 32'h0040_0004;
            e_pc = 32'hBFC0_0000;
            e_we = {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, req[3], 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
        end else if (req[1]) begin
            tag = "R4 debug";
            e_pc = 32'hBFC0_0480;
            e_we = 12'b1001_0001_0010;
        end else if (req[0]) begin
            ok = (code <= 5'd13 || code == 5'd23 || code == 5'd24) &&
                 (!refill || code == 5'd2 || code == 5'd3);
            if (ok) begin
                tag = (code == 5'd24) ? "R12 machine check" : "R8 R9 R10 general";
                e_pc = (status[22] ? 32'hBFC0_0200 : 32'h8000_0000) + (refill ? 32'h0 : 32'h180);
                e_status = status | 32'h2;
                e_cause = {in_ds, cause[30:7], code, cause[1:0]};
                e_we = 12'b1100_1100_0110;
            end else begin
                tag = "R11 unsupported";
                e_we = 12'b0000_0000_0001;
            end
        end
        if (n > 1) tag = {"R3 priority / ", tag};
    endtask

    task automatic compare();
        chk({tag, " write enables"}, {20'd0, we_vec()}, {20'd0, e_we});
        if (e_we[11]) chk({tag, " pc"}, pc_o, e_pc);
        if (e_we[10]) chk({tag, " R5 epc"}, epc_o, e_ret);
        if (e_we[9])  chk({tag, " R5 errorepc"}, errorepc_o, e_ret);
        if (e_we[8])  chk({tag, " R5 depc"}, depc_o, e_ret);
        if (e_we[7])  chk({tag, " status"}, status_o, e_status);
        if (e_we[6])  chk({tag, " cause"}, cause_o, e_cause);
    endtask

    task automatic drv(input logic [3:0] r, input logic [4:0] c, input logic rf,
                       input logic [31:0] p, input logic d, input logic [31:0] s,
                       input logic [31:0] ca);
        @(negedge clk);
        compare();
        req = r; code = c; refill = rf; pc = p; in_ds = d; status = s; cause = ca;
        model();
    endtask

    initial begin
        int unsigned cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                checks++; errors++;
                $display("FAIL watchdog expired");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        rst_n = 1'b0; req = '0; code = '0; refill = 1'b0;
        pc = '0; in_ds = 1'b0; status = '0; cause = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset write enables", {20'd0, we_vec()}, 32'd0);
        rst_n = 1'b1;
        model();
        tag = "R1 after reset";
        drv(4'b0010, 5'd0,  1'b0, 32'h0000_1000, 1'b0, 32'h0, 32'h0);
        drv(4'b0010, 5'd0,  1'b0, 32'h0000_2004, 1'b1, 32'h0, 32'h0);
        drv(4'b1000, 5'd0,  1'b0, 32'h0000_3008, 1'b1, 32'hFFFF_FFFF, 32'h0);
        drv(4'b0100, 5'd0,  1'b0, 32'h0000_4000, 1'b0, 32'h1234_0000, 32'h0);
        drv(4'b0001, 5'd8,  1'b0, 32'h0000_5000, 1'b0, 32'h0040_0000, 32'h0);
        drv(4'b0001, 5'd8,  1'b0, 32'h0000_5000, 1'b0, 32'h0000_0000, 32'h0);
        drv(4'b0001, 5'd2,  1'b1, 32'h0000_6000, 1'b0, 32'h0000_0000, 32'h0);
        drv(4'b0001, 5'd3,  1'b1, 32'h0000_6000, 1'b1, 32'h0040_0000, 32'h0);
        drv(4'b0001, 5'd24, 1'b0, 32'h0000_7004, 1'b1, 32'h0, 32'hFFFF_FFFF);
        drv(4'b0001, 5'd20, 1'b0, 32'h0000_8000, 1'b0, 32'h0, 32'h0);
        drv(4'b0001, 5'd8,  1'b1, 32'h0000_8000, 1'b0, 32'h0, 32'h0);
        drv(4'b1111, 5'd8,  1'b0, 32'h0000_9000, 1'b0, 32'h0, 32'h0);
        drv(4'b0110, 5'd8,  1'b0, 32'h0000_9000, 1'b1, 32'h0, 32'h0);
        drv(4'b0011, 5'd8,  1'b0, 32'h0000_9000, 1'b0, 32'h0, 32'h0);
        drv(4'b1001, 5'd30, 1'b0, 32'h0000_9000, 1'b0, 32'h0, 32'h0);
        drv(4'b0000, 5'd8,  1'b0, 32'h0000_9000, 1'b0, 32'h0, 32'h0);
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] r;
            r = 4'($urandom);
            if ($urandom_range(0, 2) != 0) r = {3'b000, r[0]};
            drv(r, 5'($urandom), ($urandom_range(0, 3) == 0), $urandom, 1'($urandom),
                $urandom, $urandom);
        end
        drv(4'b0000, 5'd0, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0);
        @(negedge clk);
        compare();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule